// File: doc/BRIEF.md
# Status Register Write Unit

This unit owns the processor's current status word and one saved status word and executes the two status-transfer operations: moving a status word into a general register, and moving a general register or an encoded immediate into a status word. Each operation arrives as a decoded 32-bit instruction word with a `valid_i` strobe, together with the value of the source register already read from the register file. Results appear one clock later. A register-file write request carries the value for the move-from form. The status words themselves change at the same edge.

Writes are byte-granular. Four field-enable bits in the instruction select which bytes of the target status word take the new value, and the other bytes keep their old contents. Privilege comes from the 5-bit mode field in bits 4:0 of the current status word, and mode `5'b10000` is the unprivileged user mode. In user mode only the condition flags in bits 31:28 can be written, and any access to the saved status word is rejected with an error pulse. A privileged write that alters the mode field raises a one-cycle mode-change pulse carrying the old and new modes, so the register banking logic can swap banks.

Top module: `sr_status_unit`

## Requirements
- R1: After reset the current status word holds `RESET_MODE` (default `5'b10011`) in bits 4:0 and zero in every other bit. The saved status word is zero, and `rd_we_o`, `err_o` and `mode_chg_o` are low.
- R2: The source value is `src_i` when instruction bit 25 is 0. When bit 25 is 1, the source is the 8-bit immediate in bits 7:0, zero-extended and rotated right by twice the value in bits 11:8.
- R3: Instruction bits 19, 18, 17 and 16 enable bytes 31:24, 23:16, 15:8 and 7:0. A privileged write to the current word stores (old AND NOT mask) OR (value AND mask).
- R4: A privileged write to the saved word (bit 22 = 1) applies the same byte mask to the saved word and leaves the current word unchanged.
- R5: In user mode, a write to the current word changes only bits 31:28, and only when bit 19 is set. All other bits keep their values.
- R6: In user mode, any access with bit 22 = 1 (read or write) makes `err_o` pulse high for one cycle in the cycle after the request. It changes neither status word and raises no `rd_we_o`.
- R7: A legal read (bit 21 = 0) makes `rd_we_o` pulse high one cycle later. `rd_idx_o` then equals bits 15:12, and `rd_data_o` equals the current word (bit 22 = 0) or the saved word (bit 22 = 1) as it stood when the request was accepted. A read changes neither status word.
- R8: When a privileged write to the current word changes bits 4:0, `mode_chg_o` pulses for one cycle, with `old_mode_o` and `new_mode_o` set to the modes before and after the write. No pulse occurs when the mode bits stay the same.
- R9: Bit 21 = 1 selects a write and bit 21 = 0 a read. With `valid_i` low the instruction has no effect on the status words or any pulse output.
- R10: A write's result is visible on `cur_o` or `saved_o` in the cycle after the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction strobe |
| insn_i | input | 32 | Decoded status-transfer instruction word |
| src_i | input | DATA_W | Source register value |
| cur_o | output | DATA_W | Current status word |
| saved_o | output | DATA_W | Saved status word |
| rd_we_o | output | 1 | Register-file write request for the read form |
| rd_idx_o | output | 4 | Destination register index |
| rd_data_o | output | DATA_W | Status value to write to the register file |
| err_o | output | 1 | Illegal user-mode saved-word access pulse |
| mode_chg_o | output | 1 | Mode-change pulse |
| old_mode_o | output | MODE_W | Mode before the change |
| new_mode_o | output | MODE_W | Mode after the change |

## Verification
The bench uses the default configuration: a 32-bit word, a 5-bit mode field and 4 flag bits. In this configuration the four field-enable bits have only sixteen combinations. The bench therefore sweeps every byte mask against every mode the sweep cycles through, covering both pulse and no-pulse mode outcomes. It also runs every mask under user mode and all sixteen immediate rotations against several immediates. Every expected status word is computed from the byte-merge arithmetic in the bench, so a wrong lane mapping, a wrong rotation or a missed privilege gate shows up as a word mismatch.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam logic [4:0] MODE_USER = 5'b10000;

  // fields used from the instruction word
  typedef struct packed {
    logic       is_write;
    logic       use_saved;
    logic       use_imm;
    logic [3:0] fields;
    logic [3:0] rd_idx;
    logic [3:0] rot;
    logic [7:0] imm8;
  } sr_op_t;
endpackage

// File: rtl/sr_decode.sv
module sr_decode
  import sr_pkg::*;
(
  input  logic [31:0] insn_i,
  output sr_op_t      op_o
);
  always_comb begin
    op_o.use_imm   = insn_i[25];
    op_o.use_saved = insn_i[22];
    op_o.is_write  = insn_i[21];
    op_o.fields    = insn_i[19:16];
    op_o.rd_idx    = insn_i[15:12];
    op_o.rot       = insn_i[11:8];
    op_o.imm8      = insn_i[7:0];
  end
endmodule

// File: rtl/sr_operand.sv
module sr_operand
  import sr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  sr_op_t              op_i,
  input  logic [DATA_W-1:0]   src_i,
  output logic [DATA_W-1:0]   val_o
);
  localparam int unsigned SH_W = $clog2(DATA_W) + 1;

  logic [DATA_W-1:0] imm_ext;
  logic [SH_W-1:0]   amt;
  logic [SH_W-1:0]   inv;
  logic [DATA_W-1:0] rotated;

  always_comb begin
    imm_ext = {{(DATA_W-8){1'b0}}, op_i.imm8};
    amt     = SH_W'({op_i.rot, 1'b0});
    inv     = SH_W'(DATA_W) - amt;
    // shift by full width yields zero, so amt==0 is a plain copy
    rotated = (imm_ext >> amt) | (imm_ext << inv);
    val_o   = op_i.use_imm ? rotated : src_i;
  end
endmodule

// File: rtl/sr_mask.sv
module sr_mask #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned FLAG_W = 4,
  localparam int unsigned NLANE = DATA_W / 8
) (
  input  logic [NLANE-1:0]  fields_i,
  input  logic              user_i,
  output logic [DATA_W-1:0] mask_o
);
  logic [DATA_W-1:0] lane_mask;
  logic [DATA_W-1:0] flag_mask;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign lane_mask[g*8 +: 8] = {8{fields_i[g]}};
  end

  assign flag_mask = {{FLAG_W{1'b1}}, {(DATA_W-FLAG_W){1'b0}}};
  assign mask_o    = user_i ? (lane_mask & flag_mask) : lane_mask;
endmodule

// File: rtl/sr_merge.sv
module sr_merge #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] val_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [DATA_W-1:0] new_o
);
  assign new_o = (old_i & ~mask_i) | (val_i & mask_i);
endmodule

// File: rtl/sr_status_unit.sv
module sr_status_unit
  import sr_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned MODE_W     = 5,
  parameter int unsigned FLAG_W     = 4,
  parameter logic [4:0]  RESET_MODE = 5'b10011
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [31:0]       insn_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] cur_o,
  output logic [DATA_W-1:0] saved_o,
  output logic              rd_we_o,
  output logic [3:0]        rd_idx_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              err_o,
  output logic              mode_chg_o,
  output logic [MODE_W-1:0] old_mode_o,
  output logic [MODE_W-1:0] new_mode_o
);
  localparam int unsigned NLANE = DATA_W / 8;
  localparam logic [DATA_W-1:0] CUR_RST = DATA_W'(RESET_MODE);

  sr_op_t            op;
  logic [DATA_W-1:0] val, cur_mask, sav_mask, cur_nx, sav_nx;
  logic [DATA_W-1:0] cur_q, sav_q;
  logic              is_user, illegal, wr_cur, wr_sav, do_rd, mode_diff;

  sr_decode u_dec (.insn_i(insn_i), .op_o(op));

  sr_operand #(.DATA_W(DATA_W)) u_opnd (.op_i(op), .src_i(src_i), .val_o(val));

  sr_mask #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_mask_cur (
    .fields_i(op.fields[NLANE-1:0]), .user_i(is_user), .mask_o(cur_mask)
  );
  sr_mask #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_mask_sav (
    .fields_i(op.fields[NLANE-1:0]), .user_i(1'b0), .mask_o(sav_mask)
  );

  sr_merge #(.DATA_W(DATA_W)) u_mrg_cur (
    .old_i(cur_q), .val_i(val), .mask_i(cur_mask), .new_o(cur_nx)
  );
  sr_merge #(.DATA_W(DATA_W)) u_mrg_sav (
    .old_i(sav_q), .val_i(val), .mask_i(sav_mask), .new_o(sav_nx)
  );

  always_comb begin
    is_user   = cur_q[MODE_W-1:0] == MODE_USER[MODE_W-1:0];
    illegal   = valid_i && is_user && op.use_saved;
    wr_cur    = valid_i && op.is_write && !op.use_saved;
    wr_sav    = valid_i && op.is_write && op.use_saved && !is_user;
    do_rd     = valid_i && !op.is_write && !illegal;
    mode_diff = cur_nx[MODE_W-1:0] != cur_q[MODE_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q      <= CUR_RST;
      sav_q      <= '0;
      rd_we_o    <= 1'b0;
      rd_idx_o   <= '0;
      rd_data_o  <= '0;
      err_o      <= 1'b0;
      mode_chg_o <= 1'b0;
      old_mode_o <= '0;
      new_mode_o <= '0;
    end else begin
      rd_we_o    <= do_rd;
      err_o      <= illegal;
      mode_chg_o <= wr_cur && mode_diff;
      if (do_rd) begin
        rd_idx_o  <= op.rd_idx;
        rd_data_o <= op.use_saved ? sav_q : cur_q;
      end
      if (wr_cur) begin
        cur_q <= cur_nx;
        if (mode_diff) begin
          old_mode_o <= cur_q[MODE_W-1:0];
          new_mode_o <= cur_nx[MODE_W-1:0];
        end
      end
      if (wr_sav) sav_q <= sav_nx;
    end
  end

  assign cur_o   = cur_q;
  assign saved_o = sav_q;
endmodule

// File: rtl/sr_checker.sv
module sr_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned MODE_W = 5,
  parameter int unsigned FLAG_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [31:0]       insn_i,
  input logic [DATA_W-1:0] cur_o,
  input logic [DATA_W-1:0] saved_o,
  input logic              rd_we_o,
  input logic              err_o,
  input logic              mode_chg_o,
  input logic [MODE_W-1:0] old_mode_o,
  input logic [MODE_W-1:0] new_mode_o
);
  localparam logic [MODE_W-1:0] USR = MODE_W'(5'b10000);

  logic usr;
  assign usr = cur_o[MODE_W-1:0] == USR;

  p_user_saved_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && usr && insn_i[22] |=> err_o);

  p_err_no_state_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && usr && insn_i[22] |=> cur_o == $past(cur_o) && saved_o == $past(saved_o));

  p_user_flags_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && usr && insn_i[21] && !insn_i[22]
      |=> cur_o[DATA_W-FLAG_W-1:0] == $past(cur_o[DATA_W-FLAG_W-1:0]));

  p_mode_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg_o |-> new_mode_o == cur_o[MODE_W-1:0] && old_mode_o != new_mode_o);

  p_mode_needs_change_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cur_o[MODE_W-1:0]) |-> mode_chg_o);

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(cur_o) && $stable(saved_o) && !rd_we_o && !err_o && !mode_chg_o);

  p_pulse_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_we_o, err_o, mode_chg_o}));
endmodule

bind sr_status_unit sr_checker #(.DATA_W(DATA_W), .MODE_W(MODE_W), .FLAG_W(FLAG_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .insn_i(insn_i),
  .cur_o(cur_o), .saved_o(saved_o), .rd_we_o(rd_we_o), .err_o(err_o),
  .mode_chg_o(mode_chg_o), .old_mode_o(old_mode_o), .new_mode_o(new_mode_o)
);

// File: tb/sim_sr_status_unit.sv
module sim_sr_status_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic [31:0] src_i = '0;
  logic [31:0] cur_o, saved_o, rd_data_o;
  logic        rd_we_o, err_o, mode_chg_o;
  logic [3:0]  rd_idx_o;
  logic [4:0]  old_mode_o, new_mode_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_cur, m_sav;

  always #5 clk = ~clk;

  sr_status_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .insn_i(insn_i), .src_i(src_i),
    .cur_o(cur_o), .saved_o(saved_o), .rd_we_o(rd_we_o), .rd_idx_o(rd_idx_o),
    .rd_data_o(rd_data_o), .err_o(err_o), .mode_chg_o(mode_chg_o),
    .old_mode_o(old_mode_o), .new_mode_o(new_mode_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit wr, input bit sv, input bit imm,
                                     input logic [3:0] f, input logic [3:0] rd,
                                     input logic [11:0] lo);
    logic [31:0] w = '0;
    w[25] = imm; w[22] = sv; w[21] = wr; w[19:16] = f; w[15:12] = rd; w[11:0] = lo;
    return w;
  endfunction

  // tag names the requirement the state comparison belongs to
  task automatic op(input string tag, input logic [31:0] ins, input logic [31:0] src, input bit v);
    logic [31:0] val, mask, nxt;
    logic [63:0] dbl;
    bit user, e_err, e_rd, e_chg;
    logic [31:0] e_data;
    logic [4:0] e_old;
    user = m_cur[4:0] == 5'b10000;
    dbl  = {24'h0, ins[7:0], 24'h0, ins[7:0]} >> (2 * ins[11:8]);
    val  = ins[25] ? dbl[31:0] : src;
    mask = '0;
    for (int b = 0; b < 4; b++) if (ins[16+b]) mask[b*8 +: 8] = 8'hFF;
    e_err = 0; e_rd = 0; e_chg = 0; e_data = '0; e_old = m_cur[4:0];
    if (v) begin
      if (user && ins[22]) e_err = 1;
      else if (!ins[21]) begin e_rd = 1; e_data = ins[22] ? m_sav : m_cur; end
      else if (ins[22]) m_sav = (m_sav & ~mask) | (val & mask);
      else begin
        if (user) mask = mask & 32'hF000_0000;
        nxt = (m_cur & ~mask) | (val & mask);
        e_chg = nxt[4:0] != m_cur[4:0];
        m_cur = nxt;
      end
    end
    @(negedge clk);
    valid_i = v; insn_i = ins; src_i = src;
    @(negedge clk);
    valid_i = 1'b0;
    chk({tag, " cur"}, cur_o, m_cur);
    chk({tag, " saved"}, saved_o, m_sav);
    chk("R6 err", 32'(err_o), 32'(e_err));
    chk("R7 rd_we", 32'(rd_we_o), 32'(e_rd));
    if (e_rd) begin
      chk("R7 rd_idx", 32'(rd_idx_o), 32'(ins[15:12]));
      chk("R7 rd_data", rd_data_o, e_data);
    end
    chk("R8 mode_chg", 32'(mode_chg_o), 32'(e_chg));
    if (e_chg) begin
      chk("R8 old_mode", 32'(old_mode_o), 32'(e_old));
      chk("R8 new_mode", 32'(new_mode_o), 32'(m_cur[4:0]));
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    m_cur = 32'h0000_0013; m_sav = '0;
    chk("R1 cur", cur_o, m_cur);
    chk("R1 saved", saved_o, m_sav);
    chk("R1 pulses", {29'h0, rd_we_o, err_o, mode_chg_o}, 32'h0);
  endtask

  initial begin
    logic [4:0] modes [6];
    modes = '{5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};
    m_cur = '0; m_sav = '0;
    repeat (2) @(negedge clk);
    do_reset();

    op("R7", mk(0, 0, 0, 4'h0, 4'h3, 12'h0), 32'h0, 1);
    // saved-word masks, register source
    for (int f = 0; f < 16; f++)
      op("R4", mk(1, 1, 0, 4'(f), 4'h0, 12'h0), 32'hA5C3_0000 ^ (32'h1111_1111 * f), 1);
    op("R7", mk(0, 1, 0, 4'h0, 4'h9, 12'h0), 32'h0, 1);
    // current-word masks against cycled modes
    for (int f = 0; f < 16; f++)
      for (int m = 0; m < 6; m++)
        op("R3", mk(1, 0, 0, 4'(f), 4'h0, 12'h0),
           ((32'h9E37_79B9 * (f + 1) + 32'h0101_0101 * m) & ~32'h1F) | 32'(modes[m]), 1);
    // immediate rotations
    for (int r = 0; r < 16; r++)
      foreach (modes[k])
        op("R2", mk(1, 1, 1, 4'hF, 4'h0, {4'(r), 8'(8'h81 + k * 37)}), 32'hDEAD_BEEF, 1);
    op("R2", mk(1, 0, 1, 4'h8, 4'h0, 12'h2F0), 32'h0, 1);
    // strobe low
    op("R9", mk(1, 0, 0, 4'hF, 4'h0, 12'h0), 32'h0000_0010, 0);
    op("R9", mk(1, 1, 0, 4'hF, 4'h0, 12'h0), 32'hFFFF_FFFF, 0);
    // enter user mode
    op("R10", mk(1, 0, 0, 4'h1, 4'h0, 12'h0), 32'h0000_0010, 1);
    for (int f = 0; f < 16; f++)
      op("R5", mk(1, 0, 0, 4'(f), 4'h0, 12'h0), (f % 2) ? 32'h0 : 32'hFFFF_FFFF, 1);
    op("R6", mk(1, 1, 0, 4'hF, 4'h0, 12'h0), 32'h1234_5678, 1);
    op("R6", mk(0, 1, 0, 4'h0, 4'h5, 12'h0), 32'h0, 1);
    op("R7", mk(0, 0, 0, 4'h0, 4'hE, 12'h0), 32'h0, 1);
    do_reset();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule